// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing strobes for one progressive video raster. A pixel counter and a line counter run over a frame whose total width and height are programmed. The counter positions are decoded into horizontal and vertical sync, horizontal and vertical blanking, an active-video strobe and a one-cycle frame-sync pulse. Each of the five level outputs has its own polarity bit. The vertical edges can be moved to a programmed pixel within the line.

Software programs the block through a simple 32-bit register write and read port. Timing writes land in shadow registers. A commit bit lets the working set reload only while the generator is stopped or on the last pixel of the last line, so a frame never mixes old and new timing. Three sticky event flags record the vertical blanking onset, the entry into the active line region and the frame-sync pulse. Any flag that is enabled drives the interrupt output.

Control is a two-state machine. ST_OFF holds both counters at zero and every output at its inactive level. It takes the transition "start" to ST_RUN when the run bit is 1. ST_RUN advances the counters and takes the transition "stop" back to ST_OFF when the run bit is 0. Inside ST_RUN the events "line wrap" and "frame wrap" reset the pixel counter, and the frame wrap also resets the line counter.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset every register reads 0. Each level output sits at its inactive level for polarity 0, which is 1. fsync_o and irq_o are 0.
- R2: In ST_RUN the pixel counter steps 0..HTOT-1, where HTOT is word 0x10 bits 12:0. On each pixel wrap the line counter advances through 0..VTOT-1, where VTOT is word 0x14 bits 12:0. The first ST_RUN cycle is the second clock edge after the run bit is written, and it shows pixel 0 of line 0.
- R3: Horizontal blanking is active while pixel ≥ the active width (word 0x18 bits 12:0). Horizontal sync is active while start ≤ pixel < end, with start in word 0x1C bits 12:0 and end in bits 28:16.
- R4: The effective line equals the line counter once pixel ≥ the vertical offset (word 0x24 bits 12:0). Before that point it is the previous line, and line 0 wraps back to VTOT-1. Vertical blanking is active while effective line ≥ the active height (word 0x18 bits 28:16). Vertical sync is active while start ≤ effective line < end, with start in word 0x20 bits 12:0 and end in bits 28:16.
- R5: Active video is active exactly when neither horizontal nor vertical blanking is active.
- R6: Polarity word 0x0C has bit 0 vblank, bit 1 hblank, bit 2 vsync, bit 3 hsync and bit 4 active video. A 1 drives the output equal to its active level. A 0 drives it inverted.
- R7: Control word 0x00 bit 2 is run. In ST_OFF the counters stay at zero, every level output is at its inactive level, fsync_o is 0 and no event is raised.
- R8: Control word 0x00 bit 1 is commit. The working timing (including polarity) copies the shadows only on a clock edge where commit is 1 and the block is either in ST_OFF or on the last pixel of the last line. Otherwise, shadow writes leave the outputs unchanged.
- R9: fsync_o is a one-cycle active-high pulse. It fires when the pixel counter equals word 0x28 bits 12:0 and the line counter equals bits 28:16.
- R10: Status word 0x04 holds three sticky flags. Bit 12 is set by the rise of vertical blanking. Bit 13 is set by the rise of the active line region, which happens at line 0 at the vertical offset. Bit 16 is set by the frame-sync pulse. Writing 1 to a flag clears it, but a new event in the same cycle wins.
- R11: Interrupt enable word 0x08 uses the same bit positions. irq_o is 1 exactly when some flag and its enable are both 1, one edge after either changes.
- R12: Every register reads back its fields at its own address, and unused bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| active_o | output | 1 | Active video |
| fsync_o | output | 1 | Frame-sync pulse, active high |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter-range and single-cycle-pulse assertions assume sane committed timing. The frame totals must be at least 2, and run must never start before a commit has loaded such totals. Sync and frame-sync positions must lie inside the frame. The stimulus commits each configuration while the generator is in ST_OFF, before setting the run bit. It changes the commit bit mid-frame only to move between two valid configurations. Every width, height and position it programs lies inside its frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int RTG_W  = 13;
    localparam int HI_LSB = 16;

    typedef logic [RTG_W-1:0] pos_t;

    typedef struct packed {
        pos_t       htot;
        pos_t       vtot;
        pos_t       hact;
        pos_t       vact;
        pos_t       hs_beg;
        pos_t       hs_end;
        pos_t       vs_beg;
        pos_t       vs_end;
        pos_t       voff;
        pos_t       fs_pix;
        pos_t       fs_line;
        logic [4:0] pol;
    } rtg_cfg_t;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } scan_state_t;

    localparam int POL_VB = 0;
    localparam int POL_HB = 1;
    localparam int POL_VS = 2;
    localparam int POL_HS = 3;
    localparam int POL_AV = 4;

    localparam int EV_VB = 0;
    localparam int EV_AV = 1;
    localparam int EV_FS = 2;
    localparam int EV_N  = 3;

    localparam int ST_VB_BIT = 12;
    localparam int ST_AV_BIT = 13;
    localparam int ST_FS_BIT = 16;

    localparam int CTRL_COMMIT_BIT = 1;
    localparam int CTRL_RUN_BIT    = 2;

    localparam int W_CTRL  = 0;
    localparam int W_STAT  = 1;
    localparam int W_IEN   = 2;
    localparam int W_POL   = 3;
    localparam int W_HTOT  = 4;
    localparam int W_VTOT  = 5;
    localparam int W_ACT   = 6;
    localparam int W_HSYNC = 7;
    localparam int W_VSYNC = 8;
    localparam int W_VOFF  = 9;
    localparam int W_FSYNC = 10;

endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [EV_N-1:0]   ev,
    output logic [31:0]       rdata,
    output rtg_cfg_t          shadow,
    output logic              run_en,
    output logic              commit,
    output logic              irq
);

    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    rtg_cfg_t          shadow_q;
    logic              run_q;
    logic              commit_q;
    logic [EV_N-1:0]   stat_q;
    logic [EV_N-1:0]   ien_q;
    logic [EV_N-1:0]   clr;
    logic              unused_bits;

    assign widx        = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], wdata[31:29], wdata[15:13]};

    always_comb begin
        clr = '0;
        if (we && widx == WIDX_W'(W_STAT)) begin
            clr[EV_VB] = wdata[ST_VB_BIT];
            clr[EV_AV] = wdata[ST_AV_BIT];
            clr[EV_FS] = wdata[ST_FS_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            run_q    <= 1'b0;
            commit_q <= 1'b0;
            stat_q   <= '0;
            ien_q    <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | ev;
            if (we) begin
                case (widx)
                    WIDX_W'(W_CTRL): begin
                        run_q    <= wdata[CTRL_RUN_BIT];
                        commit_q <= wdata[CTRL_COMMIT_BIT];
                    end
                    WIDX_W'(W_IEN): begin
                        ien_q[EV_VB] <= wdata[ST_VB_BIT];
                        ien_q[EV_AV] <= wdata[ST_AV_BIT];
                        ien_q[EV_FS] <= wdata[ST_FS_BIT];
                    end
                    WIDX_W'(W_POL):  shadow_q.pol  <= wdata[4:0];
                    WIDX_W'(W_HTOT): shadow_q.htot <= wdata[RTG_W-1:0];
                    WIDX_W'(W_VTOT): shadow_q.vtot <= wdata[RTG_W-1:0];
                    WIDX_W'(W_ACT): begin
                        shadow_q.hact <= wdata[RTG_W-1:0];
                        shadow_q.vact <= wdata[HI_LSB +: RTG_W];
                    end
                    WIDX_W'(W_HSYNC): begin
                        shadow_q.hs_beg <= wdata[RTG_W-1:0];
                        shadow_q.hs_end <= wdata[HI_LSB +: RTG_W];
                    end
                    WIDX_W'(W_VSYNC): begin
                        shadow_q.vs_beg <= wdata[RTG_W-1:0];
                        shadow_q.vs_end <= wdata[HI_LSB +: RTG_W];
                    end
                    WIDX_W'(W_VOFF): shadow_q.voff <= wdata[RTG_W-1:0];
                    WIDX_W'(W_FSYNC): begin
                        shadow_q.fs_pix  <= wdata[RTG_W-1:0];
                        shadow_q.fs_line <= wdata[HI_LSB +: RTG_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (widx)
            WIDX_W'(W_CTRL): begin
                rdata[CTRL_RUN_BIT]    = run_q;
                rdata[CTRL_COMMIT_BIT] = commit_q;
            end
            WIDX_W'(W_STAT): begin
                rdata[ST_VB_BIT] = stat_q[EV_VB];
                rdata[ST_AV_BIT] = stat_q[EV_AV];
                rdata[ST_FS_BIT] = stat_q[EV_FS];
            end
            WIDX_W'(W_IEN): begin
                rdata[ST_VB_BIT] = ien_q[EV_VB];
                rdata[ST_AV_BIT] = ien_q[EV_AV];
                rdata[ST_FS_BIT] = ien_q[EV_FS];
            end
            WIDX_W'(W_POL):  rdata[4:0]       = shadow_q.pol;
            WIDX_W'(W_HTOT): rdata[RTG_W-1:0] = shadow_q.htot;
            WIDX_W'(W_VTOT): rdata[RTG_W-1:0] = shadow_q.vtot;
            WIDX_W'(W_ACT): begin
                rdata[RTG_W-1:0]       = shadow_q.hact;
                rdata[HI_LSB +: RTG_W] = shadow_q.vact;
            end
            WIDX_W'(W_HSYNC): begin
                rdata[RTG_W-1:0]       = shadow_q.hs_beg;
                rdata[HI_LSB +: RTG_W] = shadow_q.hs_end;
            end
            WIDX_W'(W_VSYNC): begin
                rdata[RTG_W-1:0]       = shadow_q.vs_beg;
                rdata[HI_LSB +: RTG_W] = shadow_q.vs_end;
            end
            WIDX_W'(W_VOFF): rdata[RTG_W-1:0] = shadow_q.voff;
            WIDX_W'(W_FSYNC): begin
                rdata[RTG_W-1:0]       = shadow_q.fs_pix;
                rdata[HI_LSB +: RTG_W] = shadow_q.fs_line;
            end
            default: ;
        endcase
    end

    assign shadow = shadow_q;
    assign run_en = run_q;
    assign commit = commit_q;
    assign irq    = |(stat_q & ien_q);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        &(~($past(stat_q) & ~$past(clr)) | stat_q))
        else $error("status flag dropped without a clear"); // R10

endmodule

// File: rtl/rtg_scan.sv
module rtg_scan
    import rtg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     run_en,
    input  logic     commit,
    input  rtg_cfg_t shadow,
    output pos_t     hcnt,
    output pos_t     vcnt,
    output logic     running,
    output rtg_cfg_t work
);

    scan_state_t st_q, st_d;
    pos_t        hcnt_q, hcnt_d;
    pos_t        vcnt_q, vcnt_d;
    rtg_cfg_t    work_q;
    logic        line_end;
    logic        frame_end;
    logic        load;

    assign line_end  = hcnt_q >= work_q.htot - pos_t'(1);
    assign frame_end = line_end && (vcnt_q >= work_q.vtot - pos_t'(1));
    assign load      = commit && (st_q == ST_OFF || frame_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state and counter outputs
    always_comb begin
        st_d   = st_q;
        hcnt_d = '0;
        vcnt_d = '0;
        unique case (st_q)
            ST_OFF: begin
                if (run_en) st_d = ST_RUN;          // start
            end
            ST_RUN: begin
                if (!run_en) begin
                    st_d = ST_OFF;                  // stop
                end else if (frame_end) begin
                    hcnt_d = '0;                    // frame wrap
                    vcnt_d = '0;
                end else if (line_end) begin
                    hcnt_d = '0;                    // line wrap
                    vcnt_d = vcnt_q + pos_t'(1);
                end else begin
                    hcnt_d = hcnt_q + pos_t'(1);
                    vcnt_d = vcnt_q;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            vcnt_q <= '0;
            work_q <= '0;
        end else begin
            hcnt_q <= hcnt_d;
            vcnt_q <= vcnt_d;
            if (load) work_q <= shadow;
        end
    end

    assign hcnt    = hcnt_q;
    assign vcnt    = vcnt_q;
    assign running = (st_q == ST_RUN);
    assign work    = work_q;

    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF) |-> (hcnt_q == '0 && vcnt_q == '0))
        else $error("counters moved while stopped"); // R7

    AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (hcnt_q < work_q.htot && vcnt_q < work_q.vtot))
        else $error("counter beyond frame size"); // R2

    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && hcnt_q != '0) |-> (hcnt_q == $past(hcnt_q) + pos_t'(1)))
        else $error("pixel counter skipped"); // R2

    AST_WORK_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && (hcnt_q != '0 || vcnt_q != '0)) |-> $stable(work_q))
        else $error("working timing changed mid-frame"); // R8

endmodule

// File: rtl/rtg_shaper.sv
module rtg_shaper
    import rtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            running,
    input  pos_t            hcnt,
    input  pos_t            vcnt,
    input  rtg_cfg_t        work,
    output logic            hsync_o,
    output logic            vsync_o,
    output logic            hblank_o,
    output logic            vblank_o,
    output logic            active_o,
    output logic            fsync_o,
    output logic [EV_N-1:0] ev
);

    pos_t vline;
    logic raw_hb, raw_vb, raw_hs, raw_vs, raw_va;
    logic lvl_hb, lvl_vb, lvl_hs, lvl_vs, lvl_av, lvl_va, lvl_fs;
    logic vb_q, va_q;

    always_comb begin
        if (hcnt >= work.voff)   vline = vcnt;
        else if (vcnt == '0)     vline = work.vtot - pos_t'(1);
        else                     vline = vcnt - pos_t'(1);
    end

    assign raw_hb = hcnt >= work.hact;
    assign raw_vb = vline >= work.vact;
    assign raw_hs = (hcnt >= work.hs_beg) && (hcnt < work.hs_end);
    assign raw_vs = (vline >= work.vs_beg) && (vline < work.vs_end);
    assign raw_va = vline < work.vact;

    assign lvl_hb = running && raw_hb;
    assign lvl_vb = running && raw_vb;
    assign lvl_hs = running && raw_hs;
    assign lvl_vs = running && raw_vs;
    assign lvl_av = running && !raw_hb && !raw_vb;
    assign lvl_va = running && raw_va;
    assign lvl_fs = running && (hcnt == work.fs_pix) && (vcnt == work.fs_line);

    assign vblank_o = ~(lvl_vb ^ work.pol[POL_VB]);
    assign hblank_o = ~(lvl_hb ^ work.pol[POL_HB]);
    assign vsync_o  = ~(lvl_vs ^ work.pol[POL_VS]);
    assign hsync_o  = ~(lvl_hs ^ work.pol[POL_HS]);
    assign active_o = ~(lvl_av ^ work.pol[POL_AV]);
    assign fsync_o  = lvl_fs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vb_q <= 1'b0;
            va_q <= 1'b0;
        end else begin
            vb_q <= lvl_vb;
            va_q <= lvl_va;
        end
    end

    assign ev[EV_VB] = lvl_vb & ~vb_q;
    assign ev[EV_AV] = lvl_va & ~va_q;
    assign ev[EV_FS] = lvl_fs;

    AST_FSYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_o |=> !fsync_o)
        else $error("frame-sync pulse longer than one cycle"); // R9

    AST_VB_EVENT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        ev[EV_VB] |=> !ev[EV_VB])
        else $error("vblank event repeated"); // R10

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              hblank_o,
    output logic              vblank_o,
    output logic              active_o,
    output logic              fsync_o,
    output logic              irq_o
);

    rtg_cfg_t        shadow;
    rtg_cfg_t        work;
    logic            run_en;
    logic            commit;
    logic            running;
    pos_t            hcnt;
    pos_t            vcnt;
    logic [EV_N-1:0] ev;

    rtg_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ev     (ev),
        .rdata  (reg_rdata),
        .shadow (shadow),
        .run_en (run_en),
        .commit (commit),
        .irq    (irq_o)
    );

    rtg_scan u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .commit  (commit),
        .shadow  (shadow),
        .hcnt    (hcnt),
        .vcnt    (vcnt),
        .running (running),
        .work    (work)
    );

    rtg_shaper u_shape (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .hcnt     (hcnt),
        .vcnt     (vcnt),
        .work     (work),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .hblank_o (hblank_o),
        .vblank_o (vblank_o),
        .active_o (active_o),
        .fsync_o  (fsync_o),
        .ev       (ev)
    );

    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (ev == '0 && !fsync_o))
        else $error("event raised while stopped"); // R7

endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
    import rtg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic hsync_o, vsync_o, hblank_o, vblank_o, active_o, fsync_o, irq_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  mon_on = 1'b0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    raster_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .hblank_o(hblank_o),
        .vblank_o(vblank_o), .active_o(active_o), .fsync_o(fsync_o),
        .irq_o(irq_o)
    );

    function automatic logic [5:0] observed();
        return {fsync_o, active_o, hsync_o, vsync_o, hblank_o, vblank_o};
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // expected pins for one counter position: {fsync, active, hsync, vsync, hblank, vblank}
    function automatic logic [5:0] predict(input rtg_cfg_t c, input int h, input int v);
        int vl;
        logic hb, vb, hs, vs, av, fs;
        if (h >= int'(c.voff)) vl = v;
        else if (v == 0)       vl = int'(c.vtot) - 1;
        else                   vl = v - 1;
        hb = h >= int'(c.hact);
        vb = vl >= int'(c.vact);
        hs = (h >= int'(c.hs_beg)) && (h < int'(c.hs_end));
        vs = (vl >= int'(c.vs_beg)) && (vl < int'(c.vs_end));
        av = !hb && !vb;
        fs = (h == int'(c.fs_pix)) && (v == int'(c.fs_line));
        return {fs, ~(av ^ c.pol[4]), ~(hs ^ c.pol[3]), ~(vs ^ c.pol[2]),
                ~(hb ^ c.pol[1]), ~(vb ^ c.pol[0])};
    endfunction

    task automatic push_frame(input rtg_cfg_t c, input string tag);
        for (int v = 0; v < int'(c.vtot); v++)
            for (int h = 0; h < int'(c.htot); h++) begin
                exp_q.push_back(predict(c, h, v));
                tag_q.push_back(tag);
            end
    endtask

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({26'b0, observed()}, {26'b0, e}, t);
        end
    end

    task automatic wr(input int widx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'(widx * 4); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int widx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 8'(widx * 4);
        #1 d = reg_rdata;
    endtask

    task automatic cfg_write(input rtg_cfg_t c);
        wr(W_HTOT, 32'(c.htot));
        wr(W_VTOT, 32'(c.vtot));
        wr(W_ACT,   {3'b0, c.vact,    3'b0, c.hact});
        wr(W_HSYNC, {3'b0, c.hs_end,  3'b0, c.hs_beg});
        wr(W_VSYNC, {3'b0, c.vs_end,  3'b0, c.vs_beg});
        wr(W_VOFF, 32'(c.voff));
        wr(W_FSYNC, {3'b0, c.fs_line, 3'b0, c.fs_pix});
        wr(W_POL, 32'(c.pol));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rtg_cfg_t ca, cb, cc;
        logic [31:0] d;

        ca = '{htot:12, vtot:8, hact:8, vact:5, hs_beg:9, hs_end:11,
               vs_beg:6, vs_end:7, voff:0, fs_pix:3, fs_line:2, pol:5'h1F};
        cb = '{htot:10, vtot:7, hact:6, vact:4, hs_beg:7, hs_end:9,
               vs_beg:5, vs_end:6, voff:3, fs_pix:1, fs_line:0, pol:5'h05};
        cc = cb;
        cc.htot = 14;

        // R1 reset state
        repeat (3) @(negedge clk);
        #1 check({26'b0, observed()}, 32'h1F, "R1 outputs in reset");
        check({31'b0, irq_o}, 32'h0, "R1 irq in reset");
        @(negedge clk) rst_n = 1'b1;
        rd(W_CTRL, d); check(d, 32'h0, "R1 control after reset");
        rd(W_HSYNC, d); check(d, 32'h0, "R1 hsync word after reset");

        // config A committed while stopped, then run two frames (R2 R3 R4 R5 R6 R9)
        wr(W_CTRL, 32'h2);
        cfg_write(ca);
        wr(W_CTRL, 32'h6);
        #1;
        push_frame(ca, "R2/R3/R4/R5/R6/R9 frame A");
        push_frame(ca, "R2/R3/R4/R5/R6/R9 frame A2");
        mon_on = 1'b1;
        wait (exp_q.size() == 0);
        mon_on = 1'b0;

        // R7 stop: outputs inactive (polarity 1F -> all low)
        wr(W_CTRL, 32'h2);
        repeat (2) @(negedge clk);
        #1 check({26'b0, observed()}, 32'h00, "R7 idle after stop");
        @(negedge clk);
        #1 check({26'b0, observed()}, 32'h00, "R7 idle held");

        // R10 R11 status and interrupt
        rd(W_STAT, d); check(d, 32'h0001_3000, "R10 flags after frames");
        check({31'b0, irq_o}, 32'h0, "R11 irq masked");
        wr(W_IEN, 32'h0001_0000);
        #1 check({31'b0, irq_o}, 32'h1, "R11 irq enabled");
        wr(W_STAT, 32'h0001_0000);
        rd(W_STAT, d); check(d, 32'h0000_3000, "R10 write-one-clear");
        check({31'b0, irq_o}, 32'h0, "R11 irq after clear");
        wr(W_STAT, 32'h0000_3000);
        rd(W_STAT, d); check(d, 32'h0, "R10 all cleared");
        rd(W_IEN, d); check(d, 32'h0001_0000, "R12 enable readback");

        // R12 readback masks
        wr(W_ACT, 32'hFFFF_FFFF);
        rd(W_ACT, d); check(d, 32'h1FFF_1FFF, "R12 packed field readback");
        wr(W_POL, 32'hFFFF_FFFF);
        rd(W_POL, d); check(d, 32'h0000_001F, "R12 polarity readback");

        // config B loaded while stopped with commit, then frozen
        cfg_write(cb);
        wr(W_CTRL, 32'h0);
        @(negedge clk);
        #1 check({26'b0, observed()}, 32'h1A, "R6 mixed polarity idle levels");

        // R8: shadow change without commit is ignored; commit mid-frame applies at wrap
        wr(W_HTOT, 32'(cc.htot));
        wr(W_CTRL, 32'h4);
        #1;
        push_frame(cb, "R8/R4 frame B old timing");
        push_frame(cc, "R8 frame C after commit");
        mon_on = 1'b1;
        repeat (3) @(negedge clk);
        wr(W_CTRL, 32'h6);
        wait (exp_q.size() == 0);
        mon_on = 1'b0;
        rd(W_CTRL, d); check(d, 32'h6, "R12 control readback");

        summary();
        $finish;
    end

endmodule